// File: doc/BRIEF.md
# Free-Running Timer with Edge Capture

This block is a 16-bit up-counter that advances on every cycle in which a tick enable is high. It has one compare register and four capture channels. When the counter equals the compare value on a ticking cycle, a sticky match flag is set. If clearing is enabled, the counter restarts from zero instead of incrementing. Each capture channel synchronises its pin, detects the edge chosen for that channel, and copies the counter value into that channel's capture register. Each capture also sets a sticky flag for the channel.

Software uses an 8-bit bus to reach the counter, the compare value, the capture registers, the control byte and the status byte. The 16-bit values go through a single shared temp byte:
- Reading an upper byte latches the matching lower byte into the temp byte, and the following lower-byte read returns it.
- Writing an upper byte parks it in the temp byte, and the following lower-byte write commits all 16 bits.

A capture that lands while software is reading the upper byte of that same channel is postponed by one clock. This keeps the two byte reads coherent.

Top module: `frt_capture_unit`

## Requirements
- R1: Out of reset the counter is 0x0000. It increases by one on each clock whose `tick_en` is high, wraps from 0xFFFF to 0x0000, and holds when `tick_en` is low.
- R2: Control bit 4 enables clear-on-match. When it is 1, a ticking cycle with counter equal to the compare value makes the next counter value 0x0000. When it is 0, the counter keeps counting.
- R3: Status bit 4 is set by any ticking cycle with counter equal to the compare value, whatever the value of control bit 4. It is not set otherwise.
- R4: A lower-byte write to the counter (address 1) loads {temp, data}. This load wins over increment and over clear-on-match in the same cycle.
- R5: Control bit k (k = 0..3) selects the edge for channel k: 1 means rising, 0 means falling. A selected edge stores into the channel's capture register the counter value held two clock edges after the first edge that sampled the new pin level.
- R6: An edge of the non-selected polarity changes neither the capture register nor the channel's flag.
- R7: Status bit k is set when channel k captures. Writing 0 to a status bit clears it and writing 1 leaves it unchanged. A set arriving in the same cycle as a clear wins.
- R8: If channel k's capture would occur in a cycle with a read of its upper capture byte (address 8+2k), the capture happens one clock later, using the counter value of that later cycle. The byte pair being read returns the old value.
- R9: Addresses: 0/1 counter upper/lower, 2/3 compare upper/lower, 4 control, 5 status, 8+2k/9+2k capture k upper/lower. Reading address 0 or 8+2k latches the lower byte into the temp byte, and reading address 1 or 9+2k returns the temp byte. Writes to 0 or 2 only load the temp byte.
- R10: Reset values: compare is 0xFFFF; control, status and all capture registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable for the counter |
| cap_pin | input | 4 | Asynchronous capture inputs, one per channel |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe (drives temp-byte side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed byte |

## Verification
The hardest case to reach is the collision between a capture and an upper-byte read of the same channel. The internal strobe lives for only one clock, and it sits behind two synchroniser flops and an edge flop. The stimulus drives the pin on a falling clock edge and counts two rising edges. It then asserts the upper-byte read in exactly the cycle in which the strobe is high. The bench checks that the read pair returns the old capture and that the new value is one tick later than an undisturbed capture would be. Random channels, polarities and tick patterns cover the ordinary capture path, and the bench compares each result against its own counter model.

// File: rtl/frt_pkg.sv
package frt_pkg;
    localparam int FRT_BUS_W       = 8;
    localparam int FRT_NUM_CH      = 4;
    localparam int FRT_ADDR_W      = 4;
    localparam int FRT_SYNC_STAGES = 2;

    // byte address map
    localparam int FRT_ADR_CNT_HI   = 0;
    localparam int FRT_ADR_CNT_LO   = 1;
    localparam int FRT_ADR_CMP_HI   = 2;
    localparam int FRT_ADR_CMP_LO   = 3;
    localparam int FRT_ADR_CTRL     = 4;
    localparam int FRT_ADR_STAT     = 5;
    localparam int FRT_ADR_CAP_BASE = 8;
endpackage

// File: rtl/frt_edge_detect.sv
module frt_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic strobe
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;
    logic              level;

    assign level = sync_q[STAGES-1];

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], pin};
        prev_d = level;
        strobe = rise_sel ? (level & ~prev_q) : (~level & prev_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             clr_on_match,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign cnt = cnt_q;

    always_comb begin
        match = tick_en && (cnt_q == cmp_val);
        cnt_d = cnt_q;
        if (load_en) begin
            cnt_d = load_val;
        end else if (tick_en) begin
            if (match && clr_on_match) cnt_d = '0;
            else                       cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/frt_capture_unit.sv
module frt_capture_unit import frt_pkg::*; #(
    parameter int BUS_W       = FRT_BUS_W,
    parameter int NUM_CH      = FRT_NUM_CH,
    parameter int ADDR_W      = FRT_ADDR_W,
    parameter int SYNC_STAGES = FRT_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [NUM_CH-1:0] cap_pin,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);
    localparam int CNT_W = 2 * BUS_W;
    localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(FRT_ADR_CNT_HI);
    localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(FRT_ADR_CNT_LO);
    localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(FRT_ADR_CMP_HI);
    localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(FRT_ADR_CMP_LO);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(FRT_ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(FRT_ADR_STAT);

    typedef struct packed {
        logic [BUS_W-1:0]             tmp;
        logic [CNT_W-1:0]             cmpa;
        logic                         clr_en;
        logic [NUM_CH-1:0]            rise_sel;
        logic [NUM_CH-1:0]            cap_flag;
        logic                         match_flag;
        logic [NUM_CH-1:0]            pend;
        logic [NUM_CH-1:0][CNT_W-1:0] cap;
    } frt_state_t;

    frt_state_t s_d, s_q;

    logic [CNT_W-1:0]  cnt;
    logic              match;
    logic              cnt_load;
    logic [CNT_W-1:0]  load_val;
    logic [NUM_CH-1:0] strobe;
    logic [NUM_CH-1:0] hi_rd;
    logic [NUM_CH-1:0] fire;

    // observation nets for the bound checker
    logic [CNT_W-1:0]             cmpa_w;
    logic                         clr_en_w;
    logic                         match_flag_w;
    logic [NUM_CH-1:0]            cap_flag_w;
    logic [NUM_CH-1:0][CNT_W-1:0] cap_w;

    assign cmpa_w       = s_q.cmpa;
    assign clr_en_w     = s_q.clr_en;
    assign match_flag_w = s_q.match_flag;
    assign cap_flag_w   = s_q.cap_flag;
    assign cap_w        = s_q.cap;

    // bus decode shared by the counter and the state logic
    always_comb begin
        cnt_load = bus_wr && (bus_addr == A_CNT_LO);
        load_val = {s_q.tmp, bus_wdata};
        for (int k = 0; k < NUM_CH; k++) begin
            hi_rd[k] = bus_rd && (bus_addr == ADDR_W'(FRT_ADR_CAP_BASE + 2 * k));
        end
    end

    frt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .load_en      (cnt_load),
        .load_val     (load_val),
        .cmp_val      (s_q.cmpa),
        .clr_on_match (s_q.clr_en),
        .cnt          (cnt),
        .match        (match)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
            frt_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin      (cap_pin[g]),
                .rise_sel (s_q.rise_sel[g]),
                .strobe   (strobe[g])
            );
        end
    endgenerate

    // next-state logic
    always_comb begin
        s_d = s_q;

        // temp byte: upper-byte reads latch the lower half
        if (bus_rd && (bus_addr == A_CNT_HI)) s_d.tmp = cnt[BUS_W-1:0];
        for (int k = 0; k < NUM_CH; k++) begin
            if (hi_rd[k]) s_d.tmp = s_q.cap[k][BUS_W-1:0];
        end

        if (bus_wr) begin
            case (bus_addr)
                A_CNT_HI, A_CMP_HI: s_d.tmp = bus_wdata;
                A_CMP_LO:           s_d.cmpa = {s_q.tmp, bus_wdata};
                A_CTRL: begin
                    s_d.rise_sel = bus_wdata[NUM_CH-1:0];
                    s_d.clr_en   = bus_wdata[NUM_CH];
                end
                A_STAT: begin
                    s_d.cap_flag   = s_q.cap_flag & bus_wdata[NUM_CH-1:0];
                    s_d.match_flag = s_q.match_flag & bus_wdata[NUM_CH];
                end
                default: ;
            endcase
        end

        // capture: held back while its upper byte is being read
        for (int k = 0; k < NUM_CH; k++) begin
            fire[k]     = (strobe[k] | s_q.pend[k]) & ~hi_rd[k];
            s_d.pend[k] = (strobe[k] | s_q.pend[k]) & hi_rd[k];
            if (fire[k]) begin
                s_d.cap[k]      = cnt;
                s_d.cap_flag[k] = 1'b1;
            end
        end

        if (match) s_d.match_flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cmpa <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CNT_HI: bus_rdata = cnt[CNT_W-1:BUS_W];
            A_CNT_LO: bus_rdata = s_q.tmp;
            A_CMP_HI: bus_rdata = s_q.cmpa[CNT_W-1:BUS_W];
            A_CMP_LO: bus_rdata = s_q.cmpa[BUS_W-1:0];
            A_CTRL:   bus_rdata[NUM_CH:0] = {s_q.clr_en, s_q.rise_sel};
            A_STAT:   bus_rdata[NUM_CH:0] = {s_q.match_flag, s_q.cap_flag};
            default:  ;
        endcase
        for (int k = 0; k < NUM_CH; k++) begin
            if (bus_addr == ADDR_W'(FRT_ADR_CAP_BASE + 2 * k))
                bus_rdata = s_q.cap[k][CNT_W-1:BUS_W];
            if (bus_addr == ADDR_W'(FRT_ADR_CAP_BASE + 2 * k + 1))
                bus_rdata = s_q.tmp;
        end
    end
endmodule

// File: rtl/frt_capture_unit_checker.sv
module frt_capture_unit_checker #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick_en,
    input logic [CNT_W-1:0]             cnt,
    input logic [CNT_W-1:0]             cmpa,
    input logic                         clr_en,
    input logic                         cnt_load,
    input logic [CNT_W-1:0]             load_val,
    input logic                         match_flag,
    input logic [NUM_CH-1:0]            strobe,
    input logic [NUM_CH-1:0]            hi_rd,
    input logic [NUM_CH-1:0][CNT_W-1:0] cap,
    input logic [NUM_CH-1:0]            cap_flag
);
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_load && !(clr_en && cnt == cmpa)) |=> cnt == $past(cnt) + 1'b1);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cnt_load) |=> $stable(cnt));

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_load && clr_en && cnt == cmpa) |=> cnt == '0);

    p_match_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt == cmpa) |=> match_flag);

    p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> cnt == $past(load_val));

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
            p_capture_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (strobe[k] && !hi_rd[k]) |=> cap[k] == $past(cnt));

            p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (strobe[k] && !hi_rd[k]) |=> cap_flag[k]);

            p_read_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (strobe[k] && hi_rd[k]) |=> $stable(cap[k]));
        end
    endgenerate
endmodule

bind frt_capture_unit frt_capture_unit_checker #(
    .CNT_W  (CNT_W),
    .NUM_CH (NUM_CH)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .cnt        (cnt),
    .cmpa       (cmpa_w),
    .clr_en     (clr_en_w),
    .cnt_load   (cnt_load),
    .load_val   (load_val),
    .match_flag (match_flag_w),
    .strobe     (strobe),
    .hi_rd      (hi_rd),
    .cap        (cap_w),
    .cap_flag   (cap_flag_w)
);

// File: tb/frt_capture_unit_test.sv
module frt_capture_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] cap_pin = 4'h0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    logic tick_rand = 1'b0;
    logic tick_req  = 1'b0;
    logic [7:0]  ctrl_sh = 8'h00;
    logic [15:0] last_cap [4];

    frt_capture_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .cap_pin   (cap_pin),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #5 clk = ~clk;

    // tick enable changes 3 ns after each rising edge
    always @(posedge clk) begin
        #3;
        tick_en = tick_rand ? 1'($urandom_range(0, 1)) : tick_req;
    end

    // reference counter model built from R1, R2, R4, R9
    logic [15:0] m_cnt, m_cmp;
    logic [7:0]  m_hi;
    logic        m_clr;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 16'h0000;
            m_cmp <= 16'hFFFF;
            m_clr <= 1'b0;
            m_hi  <= 8'h00;
        end else begin
            if (bus_wr && (bus_addr == 4'd0 || bus_addr == 4'd2)) m_hi <= bus_wdata;
            if (bus_wr && bus_addr == 4'd3) m_cmp <= {m_hi, bus_wdata};
            if (bus_wr && bus_addr == 4'd4) m_clr <= bus_wdata[4];
            if (bus_wr && bus_addr == 4'd1) m_cnt <= {m_hi, bus_wdata};
            else if (tick_en) m_cnt <= (m_clr && m_cnt == m_cmp) ? 16'h0000 : m_cnt + 16'h0001;
        end
    end

    function automatic logic [3:0] cap_hi_addr(input int ch);
        return 4'(8 + 2 * ch);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr8(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd8(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] a, input logic [15:0] v);
        wr8(a, v[15:8]);
        wr8(a + 4'd1, v[7:0]);
    endtask

    task automatic rd16(input logic [3:0] a, output logic [15:0] v, output logic [15:0] snap);
        logic [7:0] h, l;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 h = bus_rdata; snap = m_cnt;
        @(negedge clk);
        bus_rd = 1'b0;
        rd8(a + 4'd1, l);
        v = {h, l};
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_req = 1'b1;
        repeat (n) @(negedge clk);
        tick_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cap_event(input int ch, input logic rising, input logic delayed);
        logic [15:0] v, sn, expv;
        logic [7:0]  st, oh, ol;
        ctrl_sh[ch] = rising;
        wr8(4'd4, ctrl_sh);
        @(negedge clk);
        cap_pin[ch] = ~rising;
        repeat (5) @(negedge clk);
        wr8(4'd5, 8'h00);
        @(negedge clk);
        cap_pin[ch] = rising;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        if (!delayed) begin
            expv = m_cnt;
            repeat (3) @(negedge clk);
        end else begin
            bus_addr = cap_hi_addr(ch); bus_rd = 1'b1;
            #2 oh = bus_rdata;
            @(negedge clk);
            expv = m_cnt;
            bus_addr = cap_hi_addr(ch) + 4'd1;
            #2 ol = bus_rdata;
            @(negedge clk);
            bus_rd = 1'b0;
            chk("R8 old pair during collision", {16'h0, oh, ol}, {16'h0, last_cap[ch]});
        end
        rd16(cap_hi_addr(ch), v, sn);
        chk(delayed ? "R8 delayed capture value" : "R5 capture value", {16'h0, v}, {16'h0, expv});
        last_cap[ch] = expv;
        rd8(4'd5, st);
        chk("R7 flag set", {31'h0, st[ch]}, 32'h1);
        wr8(4'd5, 8'hFF);
        rd8(4'd5, st);
        chk("R7 write one keeps", {31'h0, st[ch]}, 32'h1);
        wr8(4'd5, 8'h00);
        rd8(4'd5, st);
        chk("R7 write zero clears", {31'h0, st[ch]}, 32'h0);
        @(negedge clk);
        cap_pin[ch] = ~rising;
        repeat (6) @(negedge clk);
        rd16(cap_hi_addr(ch), v, sn);
        chk("R6 opposite edge keeps capture", {16'h0, v}, {16'h0, expv});
        rd8(4'd5, st);
        chk("R6 opposite edge no flag", {31'h0, st[ch]}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v, sn;
        logic [7:0]  b, h, l;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 4; i++) last_cap[i] = 16'h0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd16(4'd0, v, sn); chk("R10 counter reset", {16'h0, v}, 32'h0000);
        rd16(4'd2, v, sn); chk("R10 compare reset", {16'h0, v}, 32'hFFFF);
        rd8(4'd4, b);      chk("R10 control reset", {24'h0, b}, 32'h0);
        rd8(4'd5, b);      chk("R10 status reset", {24'h0, b}, 32'h0);
        for (int c = 0; c < 4; c++) begin
            rd16(cap_hi_addr(c), v, sn); chk("R10 capture reset", {16'h0, v}, 32'h0);
        end

        // R1 wrap and hold
        wr16(4'd0, 16'hFFFE);
        ticks(3);
        rd16(4'd0, v, sn); chk("R1 wrap", {16'h0, v}, 32'h0001);
        rd16(4'd0, v, sn); chk("R1 hold", {16'h0, v}, 32'h0001);

        // R9 coherent byte pair and temp-only upper write
        wr16(4'd0, 16'h12FF);
        rd8(4'd0, h);
        ticks(1);
        rd8(4'd1, l);
        chk("R9 latched pair", {16'h0, h, l}, 32'h12FF);
        wr8(4'd0, 8'h77);
        rd8(4'd0, h);
        chk("R9 upper write only to temp", {24'h0, h}, 32'h13);

        // R2 clear on match, R3 flag
        wr16(4'd2, 16'h0020);
        ctrl_sh = 8'h10; wr8(4'd4, ctrl_sh);
        wr16(4'd0, 16'h001C);
        wr8(4'd5, 8'h00);
        ticks(10);
        rd16(4'd0, v, sn); chk("R2 cleared on match", {16'h0, v}, 32'h0005);
        chk("R2 model agrees", {16'h0, v}, {16'h0, sn});
        rd8(4'd5, b);      chk("R3 match flag", {31'h0, b[4]}, 32'h1);

        ctrl_sh = 8'h00; wr8(4'd4, ctrl_sh);
        wr16(4'd0, 16'h001C);
        wr8(4'd5, 8'h00);
        ticks(10);
        rd16(4'd0, v, sn); chk("R2 no clear when disabled", {16'h0, v}, 32'h0026);
        rd8(4'd5, b);      chk("R3 flag without clear", {31'h0, b[4]}, 32'h1);

        wr8(4'd5, 8'h00);
        wr16(4'd0, 16'h0100);
        ticks(5);
        rd8(4'd5, b);      chk("R3 no match no flag", {31'h0, b[4]}, 32'h0);

        // R4 counter write beats clear-on-match
        wr16(4'd2, 16'h0040);
        ctrl_sh = 8'h10; wr8(4'd4, ctrl_sh);
        wr16(4'd0, 16'h0040);
        wr8(4'd5, 8'h00);
        wr8(4'd0, 8'h12);
        @(negedge clk);
        tick_req = 1'b1;
        @(negedge clk);
        tick_req = 1'b0;
        bus_addr = 4'd1; bus_wdata = 8'h34; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd16(4'd0, v, sn); chk("R4 write wins", {16'h0, v}, 32'h1234);
        rd8(4'd5, b);      chk("R3 flag on written cycle", {31'h0, b[4]}, 32'h1);

        // R7 set beats clear (match flag), R2 clear
        wr16(4'd0, 16'h0040);
        wr8(4'd5, 8'h00);
        @(negedge clk);
        tick_req = 1'b1;
        @(negedge clk);
        tick_req = 1'b0;
        bus_addr = 4'd5; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd8(4'd5, b);      chk("R7 set wins over clear", {31'h0, b[4]}, 32'h1);
        rd16(4'd0, v, sn); chk("R2 cleared at match", {16'h0, v}, 32'h0000);

        // capture channels, constant ticking
        ctrl_sh = 8'h00; wr8(4'd4, ctrl_sh);
        @(negedge clk);
        tick_req = 1'b1;
        for (int c = 0; c < 4; c++) cap_event(c, 1'(c % 2), 1'b0);
        cap_event(0, 1'b1, 1'b1);
        cap_event(3, 1'b0, 1'b1);
        cap_event(2, 1'b1, 1'b1);

        // random channels, polarities and tick patterns
        tick_rand = 1'b1;
        for (int i = 0; i < 16; i++) begin
            cap_event(int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        tick_rand = 1'b0;
        tick_req = 1'b0;

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule